// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Front-End

This block is the bus side of a two-wire serial memory slave. It runs on a fast system clock and oversamples the SCL and SDA lines. Each line passes through a two-flop synchronizer and a glitch filter. Edge logic on the filtered lines finds START and STOP conditions and the rising and falling edges of SCL. A bit engine shifts bytes MSB first and drives an open-drain pull-down enable on SDA. It uses that enable for acknowledges and for read data.

The block checks the first byte after a START against a fixed device code and the external strap pins. A parameter `HI_BITS` hands one, two or all three of the strap-compare positions to the memory sequencer as high-order memory address bits. The lowest position goes first. While the sequencer reports an internal write as busy, the block does not acknowledge its own address, so a master can poll for completion.

Received bytes leave on a valid/ready stream. `rx_valid_o` stays high with `rx_data_o` until the cycle in which `rx_ready_i` is high. No new byte can complete within one byte time, so the sequencer must take each byte before the next one ends. Read bytes enter on a second valid/ready stream. `tx_ready_o` rises when the block needs a byte and falls on the handshake or when the byte slot opens on the bus. A byte that arrives after that point is not taken.

Top module: `i2cs_eeprom_front`

## Requirements
- R1: A START (filtered SDA falls while SCL is high) begins slave-address reception from any state. A STOP (SDA rises while SCL is high) returns the block to idle, releases SDA and pulses `stop_ev_o` for one cycle.
- R2: Out of reset and before any START, the block ignores clocked traffic. It sends no acknowledge and raises no event.
- R3: The block acknowledges an address byte only if bits 7..4 equal 4'b1010 and every compared position (bits 3..1 not used as address bits) equals its strap pin. Bit 3 pairs with `strap_i[2]`, bit 2 with `strap_i[1]`, bit 1 with `strap_i[0]`. On a match it pulses `addr_ev_o` and sets `addr_rw_o` to bit 0 (1 = read).
- R4: With `HI_BITS` = n, slave-address bits 1..n appear on `addr_hi_o[n-1:0]` and are not compared. The upper bits of `addr_hi_o` read zero.
- R5: While `busy_i` is high at the eighth address bit, a matching address is not acknowledged and `addr_ev_o` stays low.
- R6: After a non-matching or refused address, the block stays idle with SDA released until the next START.
- R7: Write data is sampled on SCL rising edges, MSB first. After the eighth bit the byte appears on `rx_data_o` with `rx_valid_o`, which holds until `rx_ready_i`.
- R8: The block holds SDA low through the ninth clock of a write byte when `wr_ack_i` is high at the falling SCL edge that follows the eighth bit. Otherwise it sends NACK and ignores the bus until the next START.
- R9: Read bytes go out MSB first, each bit changing after a falling SCL edge. A byte that has not been handed over when its first bit is due goes out as 8'hFF.
- R10: In read mode SDA is released in the ninth clock. A master ACK asks for the next byte through `tx_ready_o`. A master NACK returns the block to idle with no further request.
- R11: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks have no effect. A short SDA dip with SCL high is not taken as a START.
- R12: A repeated START in the middle of a transfer, including one inside a data byte, restarts address reception without a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_i | input | 3 | Device select strap pins |
| busy_i | input | 1 | Internal write cycle in progress |
| addr_ev_o | output | 1 | One-cycle pulse: own address accepted |
| addr_rw_o | output | 1 | Direction of the accepted address (1 = read) |
| addr_hi_o | output | 3 | High memory address bits taken from the slave address |
| stop_ev_o | output | 1 | One-cycle pulse on STOP |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Sequencer accepts the received byte |
| rx_data_o | output | 8 | Received byte |
| wr_ack_i | input | 1 | Acknowledge decision for the current write byte |
| tx_valid_i | input | 1 | Read byte offered |
| tx_ready_o | output | 1 | Block wants a read byte |
| tx_data_i | input | 8 | Read byte |

## Verification
Two events can land in the same system cycle: the read-stream handshake and the falling SCL edge that opens a read byte's slot. The block forwards a byte that arrives in that very cycle straight to the shifter. The bench exercises both sides of that boundary. In one case the sequencer answers `tx_ready_o` within a cycle, long before the slot opens. In the other it withholds the byte entirely. Each case is judged by the byte the master clocks in (the arithmetic pattern, or 8'hFF) and by `tx_ready_o` being low once the byte has gone.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } i2cs_st_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int         BYTE_W   = 8;
  localparam int         SEL_W    = 3;
endpackage

// File: rtl/i2cs_deglitch.sv
module i2cs_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      cnt    <= '0;
      line_o <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 == line_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        cnt    <= '0;
        line_o <= s2;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11: the filtered line only ever moves to the value the synchronizer held
  p_filt_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != $past(line_o)) |-> ($past(s2) == line_o));
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_o = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_o  = scl_q & scl_f & ~sda_q & sda_f;
  assign rise_o  = ~scl_q & scl_f;
  assign fall_o  = scl_q & ~scl_f;

  // R1: bus conditions and clock edges never coincide
  p_cond_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int HI_BITS = 0
) (
  input  logic [6:0]       adr_i,
  input  logic [SEL_W-1:0] strap_i,
  output logic             hit_o,
  output logic [SEL_W-1:0] hi_o
);
  logic [SEL_W-1:0] sel_ok;

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    if (i < HI_BITS) begin : g_mem
      assign sel_ok[i] = 1'b1;
      assign hi_o[i]   = adr_i[i];
    end else begin : g_pin
      assign sel_ok[i] = (adr_i[i] == strap_i[i]);
      assign hi_o[i]   = 1'b0;
    end
  end

  assign hit_o = (adr_i[6:3] == DEV_CODE) && (&sel_ok);
endmodule

// File: rtl/i2cs_eeprom_front.sv
module i2cs_eeprom_front
  import i2cs_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HI_BITS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  output logic              addr_ev_o,
  output logic              addr_rw_o,
  output logic [SEL_W-1:0]  addr_hi_o,
  output logic              stop_ev_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              wr_ack_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [BYTE_W-1:0] tx_data_i
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

  logic scl_f, sda_f;
  logic cd_start, cd_stop, cd_rise, cd_fall;

  i2cs_deglitch #(.FILT_LEN(FILT_LEN)) i_dg_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  i2cs_deglitch #(.FILT_LEN(FILT_LEN)) i_dg_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  i2cs_cond_det i_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_o(cd_start), .stop_o(cd_stop), .rise_o(cd_rise), .fall_o(cd_fall));

  i2cs_st_e          st;
  logic [1:0]        ph;
  logic [BC_W-1:0]   bcnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_en;
  logic [BYTE_W-1:0] txb;
  logic              txb_full;
  logic              tx_want;
  logic              hit;
  logic [SEL_W-1:0]  hi_bits;
  logic [BYTE_W-1:0] nxt_byte;
  logic [BYTE_W-1:0] in_byte;

  assign in_byte = {shreg[BYTE_W-2:0], sda_f};

  i2cs_addr_match #(.HI_BITS(HI_BITS)) i_match (
    .adr_i(in_byte[7:1]), .strap_i(strap_i), .hit_o(hit), .hi_o(hi_bits));

  always_comb begin
    if (txb_full)                  nxt_byte = txb;
    else if (tx_want && tx_valid_i) nxt_byte = tx_data_i;
    else                           nxt_byte = '1;
  end

  assign tx_ready_o = tx_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      ack_en     <= 1'b0;
      sda_oe_o   <= 1'b0;
      addr_ev_o  <= 1'b0;
      addr_rw_o  <= 1'b0;
      addr_hi_o  <= '0;
      stop_ev_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      txb        <= '0;
      txb_full   <= 1'b0;
      tx_want    <= 1'b0;
    end else begin
      addr_ev_o <= 1'b0;
      stop_ev_o <= 1'b0;
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      if (tx_want && tx_valid_i) begin
        txb      <= tx_data_i;
        txb_full <= 1'b1;
        tx_want  <= 1'b0;
      end
      if (cd_stop) begin
        st        <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        stop_ev_o <= 1'b1;
        tx_want   <= 1'b0;
        txb_full  <= 1'b0;
      end else if (cd_start) begin
        st       <= ST_ADDR;
        bcnt     <= '0;
        sda_oe_o <= 1'b0;
        tx_want  <= 1'b0;
        txb_full <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (cd_rise) begin
            shreg <= in_byte;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == LAST_BIT) begin
              if (hit && !busy_i) begin
                st        <= ST_AACK;
                ph        <= '0;
                addr_ev_o <= 1'b1;
                addr_rw_o <= sda_f;
                addr_hi_o <= hi_bits;
                tx_want   <= sda_f;
                txb_full  <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (cd_fall) begin
            if (ph == 2'd0) begin
              sda_oe_o <= 1'b1;
              ph       <= 2'd1;
            end else if (addr_rw_o) begin
              sda_oe_o <= ~nxt_byte[BYTE_W-1];
              shreg    <= {nxt_byte[BYTE_W-2:0], 1'b0};
              bcnt     <= '0;
              txb_full <= 1'b0;
              tx_want  <= 1'b0;
              st       <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0;
              bcnt     <= '0;
              st       <= ST_WDAT;
            end
          end
          ST_WDAT: if (cd_rise) begin
            shreg <= in_byte;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == LAST_BIT) begin
              rx_data_o  <= in_byte;
              rx_valid_o <= 1'b1;
              ph         <= '0;
              st         <= ST_WACK;
            end
          end
          ST_WACK: if (cd_fall) begin
            if (ph == 2'd0) begin
              ack_en   <= wr_ack_i;
              sda_oe_o <= wr_ack_i;
              ph       <= 2'd1;
            end else begin
              sda_oe_o <= 1'b0;
              bcnt     <= '0;
              st       <= ack_en ? ST_WDAT : ST_IDLE;
            end
          end
          ST_RDAT: begin
            if (cd_rise) begin
              bcnt <= bcnt + 1'b1;
              if (bcnt == LAST_BIT) begin
                ph <= '0;
                st <= ST_RACK;
              end
            end else if (cd_fall) begin
              sda_oe_o <= ~shreg[BYTE_W-1];
              shreg    <= {shreg[BYTE_W-2:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (cd_fall && ph == 2'd0) begin
              sda_oe_o <= 1'b0;
              ph       <= 2'd1;
            end else if (cd_rise && ph == 2'd1) begin
              if (!sda_f) begin
                ph       <= 2'd2;
                tx_want  <= 1'b1;
                txb_full <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else if (cd_fall && ph == 2'd2) begin
              sda_oe_o <= ~nxt_byte[BYTE_W-1];
              shreg    <= {nxt_byte[BYTE_W-2:0], 1'b0};
              bcnt     <= '0;
              txb_full <= 1'b0;
              tx_want  <= 1'b0;
              st       <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: in idle the data line is never pulled
  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  // R1: a STOP always lands in idle with SDA released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cd_stop |=> (st == ST_IDLE && !sda_oe_o));

  // R5: no address acceptance while the write cycle was busy
  p_busy_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ev_o |-> !$past(busy_i));

  // R7: a received byte stays offered until taken
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

  // R9: the SDA drive only moves after an SCL fall or a bus condition
  p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(cd_fall || cd_start || cd_stop));
endmodule

// File: tb/test_i2cs_eeprom_front.sv
module test_i2cs_eeprom_front;
  localparam int H = 24;
  localparam logic [2:0] STRAP = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic busy = 1'b0, wr_ack = 1'b1;
  logic addr_ev, addr_rw, stop_ev, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [2:0] addr_hi;
  logic [7:0] rx_data, tx_data;
  logic tx_en = 1'b1;

  int checks = 0, errors = 0;
  int ev_n = 0, stop_n = 0, rx_n = 0, rx_drop = 0, tx_k = 0;
  logic ev_rw;
  logic [2:0] ev_hi;
  logic [7:0] rx_hist [16];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_eeprom_front #(.FILT_LEN(3), .HI_BITS(1)) i_i2cs_eeprom_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .addr_ev_o(addr_ev), .addr_rw_o(addr_rw),
    .addr_hi_o(addr_hi), .stop_ev_o(stop_ev), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data), .wr_ack_i(wr_ack),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data));

  function automatic logic [7:0] pat(int k);
    return 8'(8'h5A + k * 8'h3B);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic v);
    sda_m = v; tick(H/2); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H/2);
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tick(H/2); scl_m = 1'b1; tick(H-1);
    v = sda_line; tick(1); scl_m = 1'b0; tick(H/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(mack ? 1'b0 : 1'b1);
  endtask

  // event monitors
  initial forever begin
    @(negedge clk);
    if (addr_ev) begin ev_n++; ev_rw = addr_rw; ev_hi = addr_hi; end
    if (stop_ev) stop_n++;
  end

  // receive side of the sequencer: holds back ready to exercise back-pressure
  initial begin
    rx_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        tick(4);
        if (!rx_valid) rx_drop++;
        rx_hist[rx_n % 16] = rx_data;
        rx_n++;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    end
  end

  // transmit side of the sequencer
  initial begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (tx_valid) begin
        tx_valid = 1'b0;
        tx_k++;
      end else if (tx_ready && tx_en) begin
        tx_valid = 1'b1;
        tx_data  = pat(tx_k);
      end
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] b, rb;
    int e0, r0, s0, k0;
    tick(5); rst_n = 1'b1; tick(5);

    chk(!sda_oe, "R2 reset sda_oe", sda_oe, 0);
    chk(!rx_valid, "R7 reset rx_valid", rx_valid, 0);
    chk(!tx_ready, "R9 reset tx_ready", tx_ready, 0);

    // R2: matching byte clocked without a START
    scl_m = 1'b0; tick(H/2);
    send_byte(8'hAC, ak);
    chk(!ak, "R2 no ack without START", ak, 0);
    chk(ev_n == 0, "R2 no event without START", ev_n, 0);
    bus_stop();

    // R11: SDA dip shorter than the filter while SCL high
    tick(H); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H/2);
    send_byte(8'hAC, ak);
    chk(!ak, "R11 glitch not a START", ak, 0);
    chk(ev_n == 0, "R11 no event after glitch", ev_n, 0);
    bus_stop();

    // R3 R4 R6: address sweep
    for (int v = 0; v < 31; v++) begin
      bit exp_hit;
      b = (v < 16) ? {4'hA, 4'(v)} : {4'(v - 16), STRAP[2:1], 2'(v)};
      if (v >= 16 && b[7:4] == 4'hA) b[7:4] = 4'hF;
      exp_hit = (b[7:4] == 4'hA) && (b[3:2] == STRAP[2:1]);
      e0 = ev_n;
      bus_start();
      send_byte(b, ak);
      chk(ak == exp_hit, $sformatf("R3 ack for %02h", b), ak, exp_hit);
      chk(ev_n == e0 + (exp_hit ? 1 : 0), "R3 address event", ev_n - e0, exp_hit);
      if (exp_hit) begin
        chk(ev_rw == b[0], "R3 rw bit", ev_rw, b[0]);
        chk(ev_hi == {2'b00, b[1]}, "R4 high address bits", ev_hi, {2'b00, b[1]});
        if (b[0]) recv_byte(1'b0, rb);
      end else begin
        send_byte(8'h00, ak);
        chk(!ak && !sda_oe, "R6 stays released after mismatch", ak, 0);
      end
      bus_stop();
    end

    // R5: busy refuses the address, then polling succeeds
    busy = 1'b1; e0 = ev_n;
    bus_start(); send_byte(8'hAC, ak);
    chk(!ak, "R5 busy NACK", ak, 0);
    chk(ev_n == e0, "R5 no event while busy", ev_n - e0, 0);
    send_byte(8'h00, ak);
    chk(!ak, "R6 ignored after refusal", ak, 0);
    bus_stop(); busy = 1'b0;
    bus_start(); send_byte(8'hAC, ak);
    chk(ak, "R5 ack once idle", ak, 1);
    bus_stop();

    // R7 R8 R1: write two bytes
    r0 = rx_n; s0 = stop_n;
    bus_start(); send_byte(8'hAC, ak);
    send_byte(8'h3C, ak); chk(ak, "R8 ack byte 1", ak, 1);
    send_byte(8'hC5, ak); chk(ak, "R8 ack byte 2", ak, 1);
    bus_stop(); tick(4);
    chk(rx_n == r0 + 2, "R7 byte count", rx_n - r0, 2);
    chk(rx_hist[r0 % 16] == 8'h3C, "R7 byte 1 value", rx_hist[r0 % 16], 8'h3C);
    chk(rx_hist[(r0 + 1) % 16] == 8'hC5, "R7 byte 2 value", rx_hist[(r0 + 1) % 16], 8'hC5);
    chk(stop_n == s0 + 1, "R1 stop event", stop_n - s0, 1);
    chk(!sda_oe, "R1 released after STOP", sda_oe, 0);

    // R8: refused write byte, rest ignored
    r0 = rx_n;
    bus_start(); send_byte(8'hAC, ak);
    wr_ack = 1'b0; send_byte(8'h77, ak); wr_ack = 1'b1;
    chk(!ak, "R8 NACK when refused", ak, 0);
    send_byte(8'h11, ak);
    chk(!ak, "R8 ignored after NACK", ak, 0);
    bus_stop(); tick(4);
    chk(rx_n == r0 + 1, "R8 only refused byte delivered", rx_n - r0, 1);

    // R9 R10: sequential read
    k0 = tx_k;
    bus_start(); send_byte(8'hAD, ak);
    chk(ak, "R9 read address ack", ak, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i < 2, rb);
      chk(rb == pat(k0 + i), "R9 read byte", rb, pat(k0 + i));
    end
    chk(!tx_ready, "R10 no request after NACK", tx_ready, 0);
    bus_stop();
    chk(!sda_oe, "R10 released after read", sda_oe, 0);

    // R9: byte never handed over
    tx_en = 1'b0;
    bus_start(); send_byte(8'hAD, ak);
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF, "R9 late byte reads FF", rb, 8'hFF);
    chk(!tx_ready, "R9 request withdrawn", tx_ready, 0);
    bus_stop(); tx_en = 1'b1;

    // R12: repeated START after address byte, then inside a data byte
    r0 = rx_n; k0 = tx_k;
    bus_start(); send_byte(8'hAC, ak); send_byte(8'h40, ak);
    bus_start(); send_byte(8'hAD, ak);
    chk(ak, "R12 ack after repeated START", ak, 1);
    recv_byte(1'b0, rb);
    chk(rb == pat(k0), "R12 read after repeated START", rb, pat(k0));
    bus_stop(); tick(4);
    chk(rx_hist[r0 % 16] == 8'h40, "R12 address byte received", rx_hist[r0 % 16], 8'h40);
    bus_start(); send_byte(8'hAC, ak);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start(); send_byte(8'hAF, ak);
    chk(ak, "R12 ack after mid-byte START", ak, 1);
    chk(ev_hi == 3'b001 && ev_rw, "R12 new address taken", {ev_hi, ev_rw}, 4'b0011);
    recv_byte(1'b0, rb);
    bus_stop(); tick(4);
    chk(rx_drop == 0, "R7 valid held until ready", rx_drop, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule